// File: doc/BRIEF.md
# Wide Write Width Negotiator

This block is the data-path controller of a bus initiator with a 64-bit data path. It takes one write request at a time. The request carries a dword address, a 64-bit data word, eight active-high byte enables and a flag that marks the target as memory. The block runs one address clock and then one data phase. For a memory target it asks for a 64-bit transfer, and it raises that request together with the frame. It then watches the claim from the target and the wide acknowledge that comes with it.

If the claim arrives with the acknowledge, all eight bytes go in one data phase. If the claim arrives without it, the upper dword is moved onto the low lanes in the next clock and sent as a second 32-bit phase. That phase is dropped when none of the upper byte enables is set. A request to a non-memory target never asks for width, and it always sends its data as dwords. When no claim arrives within a fixed window, the transaction ends in a master abort. A parity bit over the upper data lanes and the upper byte enables follows the bus one clock behind.

The states are IDLE, ADDR, DATA and UPPER. Transitions: IDLE→ADDR on an accepted request. ADDR→DATA always. DATA→IDLE on a claim that needs no second phase, or on the timeout. DATA→UPPER on a claim without width when an upper enable is set. UPPER→IDLE always.

Top module: `wide_write_negotiator`

## Requirements
- R1: `bus_req_wide` is high in exactly the clocks in which `bus_frame` is high, for a memory request (`req_mem`=1). It is low throughout for a non-memory request.
- R2: The address clock lasts one cycle. It drives `req_addr` on `bus_ad[31:0]`, and on `bus_cbe[3:0]` it drives 4'b0111 for memory or 4'b0011 otherwise. `bus_ad[63:32]`, `bus_cbe[7:4]` and `bus_irdy` are zero in that clock.
- R3: In every DATA clock, `bus_irdy` and `bus_frame` are high. A memory request drives all 64 data bits on `bus_ad` and all 8 enables on `bus_cbe` (bit i enables byte i). DATA lasts until `tgt_claim` is sampled high.
- R4: A claim together with `tgt_wide_ack` on a memory request raises `xfer_done` in that clock. The block is IDLE the next clock. `xfer_done` and `xfer_abort` are never high together.
- R5: A claim without width, with any of `req_be[7:4]` set, is followed by one UPPER clock. In that clock `bus_ad[31:0]` holds data[63:32], `bus_cbe[3:0]` holds be[7:4], the upper lanes are zero and `xfer_done` is high.
- R6: When `req_be[7:4]` are all zero, a claim without width completes in the claim clock with `xfer_done`, and no UPPER clock follows.
- R7: For a non-memory request, `tgt_wide_ack` is ignored. `bus_ad[63:32]` and `bus_cbe[7:4]` are zero in every clock of the frame.
- R8: If `tgt_claim` is not seen in the first 5 DATA clocks, `xfer_abort` is high in the 5th. In the next clock the frame and `bus_irdy` are low. A claim in the 5th clock wins over the abort.
- R9: `bus_par_hi` equals the XOR of `bus_ad[63:32]` and `bus_cbe[7:4]` from the previous clock. It is 0 after reset.
- R10: During reset and in IDLE, all bus outputs are zero and `req_ready` is high. `req_valid` is taken only while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request strobe |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | 32 | Dword address |
| req_data | input | 64 | Write data |
| req_be | input | 8 | Byte enables, active high |
| req_mem | input | 1 | Target is memory, allows width |
| tgt_claim | input | 1 | Target claims and accepts the data phase |
| tgt_wide_ack | input | 1 | Target accepts 64-bit width |
| bus_frame | output | 1 | Transaction in progress |
| bus_req_wide | output | 1 | 64-bit transfer requested |
| bus_irdy | output | 1 | Initiator data valid |
| bus_ad | output | 64 | Address/data lanes |
| bus_cbe | output | 8 | Command / byte enables |
| bus_par_hi | output | 1 | Even parity over upper lanes and enables, one clock late |
| xfer_done | output | 1 | Last data phase completes this clock |
| xfer_abort | output | 1 | Master abort this clock |

## Verification
A claim can arrive in the fifth and last DATA clock, so the claim and the timeout meet in the same cycle. The bench presents a claim at that slot, both with and without the width acknowledge. It expects completion or a fallback phase, with `xfer_abort` low. The parity of the shifted upper dword also falls in the clock after the fallback phase. It is judged against a model that keeps the expected lanes of the previous cycle.

// File: rtl/wnego_pkg.sv
package wnego_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_DATA  = 2'd2,
        ST_UPPER = 2'd3
    } wn_state_t;

    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;
    localparam logic [3:0] CMD_IO_WRITE  = 4'b0011;
endpackage

// File: rtl/wn_claim_timer.sv
module wn_claim_timer #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last_slot
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_slot = run && (cnt_q == CW'(LIMIT - 1));

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < CW'(LIMIT))); // R8
endmodule

// File: rtl/wn_upper_parity.sv
module wn_upper_parity #(
    parameter int HW  = 32,
    parameter int HBW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HW-1:0]  hi_lanes,
    input  logic [HBW-1:0] hi_be,
    output logic           par_hi
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_hi <= 1'b0;
        end else begin
            par_hi <= ^{hi_lanes, hi_be};
        end
    end
endmodule

// File: rtl/wide_write_negotiator.sv
module wide_write_negotiator
    import wnego_pkg::*;
#(
    parameter int DW          = 64,
    parameter int CLAIM_LIMIT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [DW/2-1:0] req_addr,
    input  logic [DW-1:0]   req_data,
    input  logic [DW/8-1:0] req_be,
    input  logic            req_mem,
    input  logic            tgt_claim,
    input  logic            tgt_wide_ack,
    output logic            bus_frame,
    output logic            bus_req_wide,
    output logic            bus_irdy,
    output logic [DW-1:0]   bus_ad,
    output logic [DW/8-1:0] bus_cbe,
    output logic            bus_par_hi,
    output logic            xfer_done,
    output logic            xfer_abort
);
    localparam int HW  = DW / 2;
    localparam int BW  = DW / 8;
    localparam int HBW = BW / 2;

    wn_state_t      state_q, state_d;
    logic [HW-1:0]  addr_q;
    logic [DW-1:0]  data_q;
    logic [BW-1:0]  be_q;
    logic           wide_q;
    logic           accept;
    logic           hi_be_any;
    logic           wide_ok;
    logic           last_slot;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign hi_be_any = |be_q[BW-1:HBW];
    assign wide_ok   = wide_q && tgt_wide_ack;

    wn_claim_timer #(.LIMIT(CLAIM_LIMIT)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q == ST_DATA),
        .last_slot (last_slot)
    );

    wn_upper_parity #(.HW(HW), .HBW(HBW)) i_parity (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_lanes (bus_ad[DW-1:HW]),
        .hi_be    (bus_cbe[BW-1:HBW]),
        .par_hi   (bus_par_hi)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            be_q    <= '0;
            wide_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= req_addr;
                data_q <= req_data;
                be_q   <= req_be;
                wide_q <= req_mem;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_DATA;
            ST_DATA: begin
                if (tgt_claim) begin
                    state_d = (wide_ok || !hi_be_any) ? ST_IDLE : ST_UPPER;
                end else if (last_slot) begin
                    state_d = ST_IDLE;
                end
            end
            ST_UPPER: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready    = 1'b0;
        bus_frame    = 1'b0;
        bus_req_wide = 1'b0;
        bus_irdy     = 1'b0;
        bus_ad       = '0;
        bus_cbe      = '0;
        xfer_done    = 1'b0;
        xfer_abort   = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_ADDR: begin
                bus_frame          = 1'b1;
                bus_req_wide       = wide_q;
                bus_ad[HW-1:0]     = addr_q;
                bus_cbe[HBW-1:0]   = wide_q ? CMD_MEM_WRITE : CMD_IO_WRITE;
            end
            ST_DATA: begin
                bus_frame    = 1'b1;
                bus_req_wide = wide_q;
                bus_irdy     = 1'b1;
                if (wide_q) begin
                    bus_ad  = data_q;
                    bus_cbe = be_q;
                end else begin
                    bus_ad[HW-1:0]   = data_q[HW-1:0];
                    bus_cbe[HBW-1:0] = be_q[HBW-1:0];
                end
                xfer_done  = tgt_claim && (wide_ok || !hi_be_any);
                xfer_abort = !tgt_claim && last_slot;
            end
            ST_UPPER: begin
                bus_frame        = 1'b1;
                bus_req_wide     = wide_q;
                bus_irdy         = 1'b1;
                bus_ad[HW-1:0]   = data_q[DW-1:HW];
                bus_cbe[HBW-1:0] = be_q[BW-1:HBW];
                xfer_done        = 1'b1;
            end
            default: req_ready = 1'b0;
        endcase
    end

    AST_WIDE_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_wide |-> bus_frame); // R1
    AST_WIDE_RISES_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_wide) |-> $rose(bus_frame)); // R1
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_done && xfer_abort)); // R4
    AST_UPPER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && tgt_claim && !wide_ok && hi_be_any)
        |=> (bus_irdy && bus_ad[HW-1:0] == $past(data_q[DW-1:HW]))); // R5
    AST_NARROW_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_frame && !bus_req_wide)
        |-> (bus_ad[DW-1:HW] == '0 && bus_cbe[BW-1:HBW] == '0)); // R7
    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |=> (!bus_frame && !bus_irdy)); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_frame |-> !req_ready); // R10
endmodule

// File: tb/test_wide_write_negotiator.sv
module test_wide_write_negotiator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic [7:0]  req_be = '0;
    logic        req_mem = 1'b0;
    logic        tgt_claim = 1'b0;
    logic        tgt_wide_ack = 1'b0;
    logic        bus_frame, bus_req_wide, bus_irdy, bus_par_hi, xfer_done, xfer_abort;
    logic [63:0] bus_ad;
    logic [7:0]  bus_cbe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wide_write_negotiator i_wide_write_negotiator (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be), .req_mem(req_mem),
        .tgt_claim(tgt_claim), .tgt_wide_ack(tgt_wide_ack), .bus_frame(bus_frame),
        .bus_req_wide(bus_req_wide), .bus_irdy(bus_irdy), .bus_ad(bus_ad),
        .bus_cbe(bus_cbe), .bus_par_hi(bus_par_hi), .xfer_done(xfer_done),
        .xfer_abort(xfer_abort)
    );

    // Reference model: 0 idle, 1 address, 2 data, 3 upper phase
    int          m_st = 0;
    int          m_cnt = 0;
    logic [31:0] m_addr = '0;
    logic [63:0] m_data = '0;
    logic [7:0]  m_be = '0;
    logic        m_mem = 1'b0;
    logic        m_par = 1'b0;

    logic        e_ready, e_frame, e_wide, e_irdy, e_done, e_abort;
    logic [63:0] e_ad;
    logic [7:0]  e_cbe;
    string       tag;

    always_comb begin
        e_ready = (m_st == 0);
        e_frame = (m_st != 0);
        e_wide  = (m_st != 0) && m_mem;
        e_irdy  = (m_st >= 2);
        e_ad    = '0;
        e_cbe   = '0;
        e_done  = 1'b0;
        e_abort = 1'b0;
        tag     = "R10";
        if (m_st == 1) begin
            tag = "R2";
            e_ad[31:0] = m_addr;
            e_cbe[3:0] = m_mem ? 4'b0111 : 4'b0011;
        end else if (m_st == 2) begin
            tag = m_mem ? "R3" : "R7";
            e_ad[31:0] = m_data[31:0];
            e_cbe[3:0] = m_be[3:0];
            if (m_mem) begin
                e_ad[63:32] = m_data[63:32];
                e_cbe[7:4]  = m_be[7:4];
            end
            if (tgt_claim) begin
                if (m_mem && tgt_wide_ack) begin
                    e_done = 1'b1; tag = "R4";
                end else if (m_be[7:4] == 4'h0) begin
                    e_done = 1'b1; tag = "R6";
                end
            end else if (m_cnt == 4) begin
                e_abort = 1'b1; tag = "R8";
            end
        end else if (m_st == 3) begin
            tag = "R5";
            e_ad[31:0] = m_data[63:32];
            e_cbe[3:0] = m_be[7:4];
            e_done = 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_par <= 1'b0;
        end else begin
            m_par <= ^{e_ad[63:32], e_cbe[7:4]};
            case (m_st)
                0: if (req_valid) begin
                    m_addr <= req_addr; m_data <= req_data;
                    m_be <= req_be; m_mem <= req_mem; m_st <= 1;
                end
                1: begin m_st <= 2; m_cnt <= 0; end
                2: begin
                    if (tgt_claim) m_st <= e_done ? 0 : 3;
                    else if (m_cnt == 4) m_st <= 0;
                    else m_cnt <= m_cnt + 1;
                end
                default: m_st <= 0;
            endcase
        end
    end

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            check(rst_n ? tag : "R10", "req_ready", 64'(req_ready), 64'(e_ready));
            check(rst_n ? "R1" : "R10", "bus_frame", 64'(bus_frame), 64'(e_frame));
            check(rst_n ? "R1" : "R10", "bus_req_wide", 64'(bus_req_wide), 64'(e_wide));
            check(rst_n ? tag : "R10", "bus_irdy", 64'(bus_irdy), 64'(e_irdy));
            check(rst_n ? tag : "R10", "bus_ad", bus_ad, e_ad);
            check(rst_n ? tag : "R10", "bus_cbe", 64'(bus_cbe), 64'(e_cbe));
            check(rst_n ? "R9" : "R10", "bus_par_hi", 64'(bus_par_hi), 64'(m_par));
            check(rst_n ? tag : "R10", "xfer_done", 64'(xfer_done), 64'(e_done));
            check(rst_n ? "R8" : "R10", "xfer_abort", 64'(xfer_abort), 64'(e_abort));
        end
    end

    task automatic summary();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            summary();
        end
    end

    // One transaction: claim after dly data clocks (claim=0: none), noise = req_valid held while busy
    task automatic txn(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be,
                       input logic mem, input int dly, input bit claim, input bit ack,
                       input bit noise);
        @(posedge clk); #2;
        req_valid = 1'b1; req_addr = a; req_data = d; req_be = be; req_mem = mem;
        @(posedge clk); #2;
        req_valid = noise; req_data = ~d; req_be = ~be; req_mem = ~mem;
        @(posedge clk); #2;
        if (claim) begin
            for (int i = 0; i < dly; i++) begin @(posedge clk); #2; end
            req_valid = 1'b0;
            tgt_claim = 1'b1; tgt_wide_ack = ack;
            @(posedge clk); #2;
            tgt_claim = 1'b0; tgt_wide_ack = 1'b0;
        end else begin
            for (int i = 0; i < 5; i++) begin @(posedge clk); #2; end
            req_valid = 1'b0;
        end
        tgt_wide_ack = ack; // wide ack outside a claim has no effect
        for (int i = 0; i < 3; i++) begin @(posedge clk); #2; end
        tgt_wide_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R4: wide accepted at once
        txn(32'h1000_0040, 64'hA5A5_0F0F_1234_5678, 8'hFF, 1'b1, 0, 1, 1, 0);
        // R5: narrow target, fallback phase after delay
        txn(32'h1000_0048, 64'hDEAD_BEEF_CAFE_F00D, 8'hF3, 1'b1, 2, 1, 0, 0);
        // R6: upper enables empty, no second phase
        txn(32'h1000_0050, 64'h1111_2222_3333_4444, 8'h0F, 1'b1, 1, 1, 0, 0);
        // R7: non-memory request, wide ack ignored
        txn(32'h0000_0CF8, 64'h8000_0001_7654_3210, 8'hC1, 1'b0, 0, 1, 1, 0);
        // R8: no claim, master abort
        txn(32'h2000_0000, 64'h0123_4567_89AB_CDEF, 8'hFF, 1'b1, 0, 0, 0, 0);
        // R8: claim in the last slot wins, wide and fallback
        txn(32'h2000_0008, 64'hFFFF_0000_FFFF_0000, 8'hFF, 1'b1, 4, 1, 1, 0);
        txn(32'h2000_0010, 64'h8421_8421_0000_0001, 8'h80, 1'b1, 4, 1, 0, 0);
        // R10: request held while busy is ignored
        txn(32'h3000_0000, 64'h5555_AAAA_3C3C_C3C3, 8'h3C, 1'b1, 3, 1, 0, 1);
        for (int k = 0; k < 16; k++) begin
            txn(32'h4000_0000 + 32'(k * 8), {32'(k * 32'h0101_0101), 32'(~k)},
                8'(k * 37), k[0], k % 5, (k % 7) != 6, k[1], k[2]);
        end
        repeat (4) @(posedge clk);
        summary();
    end
endmodule